// File: doc/BRIEF.md
# Interleaved Multiphase PWM Sequencer

This block sequences the PWM outputs of a multiphase buck controller with two to four phases. A free-running cycle counter with a programmable period produces one turn-off event per active channel. The events are spread evenly around the cycle, and channel 1 defines the start of each cycle. After a turn-off, a channel is held low for a forced off window of a quarter cycle. During that window the block pulses a sample strobe so that the channel's load current can be measured. Once the window has ended, the channel goes high as soon as its compare input (the synchronous result of an external ramp-versus-control comparator) is seen high. It then stays high until its next turn-off event.

The number of active phases comes from two strap-detect inputs, which report whether the channel-3 or channel-4 output pin is tied high. The straps and the period are captured only while reset is held. Unused channels are held low and never drive.

Top module: `mphPwmSeq`

## Requirements
- R1: While `rstN` is low, every `pwmOut` bit and `sampleStb` are 0. `strapCh3`, `strapCh4` and `cfgPeriod` are captured only during reset. Changing them after reset release does not change the channel count or the period.
- R2: The channel count N is 2 if `strapCh3` is 1, else 3 if `strapCh4` is 1, else 4. Bits of `pwmOut` at index N or above stay 0 whatever `cmpHit` does.
- R3: The effective period P is `cfgPeriod` clocks, raised to 8 when `cfgPeriod` is below 8. Channel index 0 has a turn-off event at the first rising edge after reset release, and again every P edges.
- R4: Channel index k (k < N) has its turn-off event k*floor(P/N) edges after the channel-0 event of the same cycle. Any remainder lengthens the last phase.
- R5: After a turn-off, the channel output stays 0 for at least Q = floor(P/4) clocks, even if its `cmpHit` bit is 1 throughout that time.
- R6: A channel may rise only at an edge Q or more edges after its turn-off, and only at an edge where its `cmpHit` bit is 1. If `cmpHit` is already 1 when the window ends, the output rises at the very first such edge. No channel rises before its first turn-off event.
- R7: Once high, a channel output stays high until its next turn-off event, even if its `cmpHit` bit falls.
- R8: For each turn-off of channel k, `sampleStb` is 1 for exactly one clock, floor(Q/2) clocks after the turn-off edge. In that clock `sampleCh` equals k, where index 0 is channel 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset; straps and period are captured while it is low |
| cfgPeriod | input | CNT_W | Switching period in system clocks (minimum 8) |
| strapCh3 | input | 1 | Channel-3 pin detected tied high (selects two-channel mode) |
| strapCh4 | input | 1 | Channel-4 pin detected tied high (selects three-channel mode) |
| cmpHit | input | 4 | Per-channel ramp-crossing compare result, bit k for channel index k |
| pwmOut | output | 4 | PWM outputs, bit k for channel index k |
| sampleStb | output | 1 | One-clock current-sample strobe in the middle of a forced off window |
| sampleCh | output | 2 | Channel index the current strobe belongs to |

## Verification
The hardest case to reach is a compare input that is already high while the forced off window is still open. It must be ignored up to the exact edge where the window closes, and the output must rise on that very edge. The stimulus drives channel 0's compare high through the whole window, then low, then high for a single clock. Each step is timed against a cycle count taken from reset release, so the output can be checked on both sides of each edge. Straps and period are also changed after release, in the same run, to show that they have no effect.

// File: rtl/mphPwmPkg.sv
package mphPwmPkg;
  localparam int MAX_CH     = 4;
  localparam int CH_W       = 2;
  localparam int NCH_W      = 3;
  localparam int MIN_PERIOD = 8;

  // Strobes from the control to the per-channel datapath
  typedef struct packed {
    logic [MAX_CH-1:0] turnOff;
    logic [MAX_CH-1:0] chEn;
  } ctlStb_t;

  // Strap decode: pin 3 tied high has priority (two phases), then pin 4 (three)
  function automatic logic [NCH_W-1:0] chanCount(input logic s3, input logic s4);
    if (s3)      return NCH_W'(2);
    else if (s4) return NCH_W'(3);
    else         return NCH_W'(4);
  endfunction
endpackage

// File: rtl/mphPwmCtl.sv
module mphPwmCtl
  import mphPwmPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic             strapCh3,
  input  logic             strapCh4,
  output ctlStb_t          ctlStb,
  output logic [CNT_W-1:0] qtrLen
);
  logic [CNT_W-1:0] effPer;
  logic [NCH_W-1:0] nSel;
  logic [CNT_W-1:0] perReg;
  logic [CNT_W-1:0] stepReg;
  logic [CNT_W-1:0] qtrReg;
  logic [NCH_W-1:0] nAct;
  logic [CNT_W-1:0] cnt;

  assign effPer = (cfgPeriod < CNT_W'(MIN_PERIOD)) ? CNT_W'(MIN_PERIOD) : cfgPeriod;
  assign nSel   = chanCount(strapCh3, strapCh4);

  // Configuration is captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      perReg  <= effPer;
      nAct    <= nSel;
      stepReg <= effPer / CNT_W'(nSel);
      qtrReg  <= effPer >> 2;
      cnt     <= '0;
    end else begin
      cnt <= (cnt == perReg - CNT_W'(1)) ? '0 : cnt + CNT_W'(1);
    end
  end

  for (genvar k = 0; k < MAX_CH; k++) begin : gOff
    logic [CNT_W-1:0] offs;
    assign offs                 = CNT_W'(k) * stepReg;
    assign ctlStb.chEn[k]       = (NCH_W'(k) < nAct);
    assign ctlStb.turnOff[k]    = ctlStb.chEn[k] && (cnt == offs);
  end

  assign qtrLen = qtrReg;
endmodule

// File: rtl/mphPwmPhase.sv
module mphPwmPhase
  import mphPwmPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           ctlStb,
  input  logic [CNT_W-1:0]  qtrLen,
  input  logic [MAX_CH-1:0] cmpHit,
  output logic [MAX_CH-1:0] pwmOut,
  output logic              sampleStb,
  output logic [CH_W-1:0]   sampleCh
);
  logic [CNT_W-1:0]  midVal;
  logic [MAX_CH-1:0] midHit;

  // hold counts qtrLen..1 across the window; the midpoint is floor(Q/2) clocks in
  assign midVal = qtrLen - (qtrLen >> 1);

  for (genvar k = 0; k < MAX_CH; k++) begin : gCh
    logic [CNT_W-1:0] hold;
    logic             armed;
    logic             pwmR;

    always_ff @(posedge clk) begin
      if (!rstN || !ctlStb.chEn[k]) begin
        pwmR  <= 1'b0;
        hold  <= '0;
        armed <= 1'b0;
      end else if (ctlStb.turnOff[k]) begin
        pwmR  <= 1'b0;
        hold  <= qtrLen;
        armed <= 1'b1;
      end else begin
        if (hold != '0) hold <= hold - CNT_W'(1);
        if (armed && (hold <= CNT_W'(1)) && cmpHit[k]) pwmR <= 1'b1;
      end
    end

    assign pwmOut[k] = pwmR;
    assign midHit[k] = ctlStb.chEn[k] && (hold == midVal);
  end

  always_comb begin
    sampleCh = '0;
    for (int k = 0; k < MAX_CH; k++) begin
      if (midHit[k]) sampleCh = CH_W'(k);
    end
  end

  assign sampleStb = |midHit;
endmodule

// File: rtl/mphPwmSeq.sv
module mphPwmSeq
  import mphPwmPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic             strapCh3,
  input  logic             strapCh4,
  input  logic [3:0]       cmpHit,
  output logic [3:0]       pwmOut,
  output logic             sampleStb,
  output logic [1:0]       sampleCh
);
  ctlStb_t          ctlStb;
  logic [CNT_W-1:0] qtrLen;

  mphPwmCtl #(.CNT_W(CNT_W)) uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgPeriod (cfgPeriod),
    .strapCh3  (strapCh3),
    .strapCh4  (strapCh4),
    .ctlStb    (ctlStb),
    .qtrLen    (qtrLen)
  );

  mphPwmPhase #(.CNT_W(CNT_W)) uPhase (
    .clk       (clk),
    .rstN      (rstN),
    .ctlStb    (ctlStb),
    .qtrLen    (qtrLen),
    .cmpHit    (cmpHit),
    .pwmOut    (pwmOut),
    .sampleStb (sampleStb),
    .sampleCh  (sampleCh)
  );
endmodule

// File: rtl/mphPwmSeqChk.sv
module mphPwmSeqChk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [3:0]       pwmOut,
  input logic [3:0]       cmpHit,
  input logic [3:0]       turnOff,
  input logic [3:0]       chEn,
  input logic [CNT_W-1:0] qtrLen,
  input logic             sampleStb,
  input logic [1:0]       sampleCh
);
  a_r1_reset_quiet: assert property (@(posedge clk) !rstN |=> (pwmOut == 4'b0));

  a_r2_unused_low: assert property (@(posedge clk) disable iff (!rstN)
    (pwmOut & ~chEn) == 4'b0);

  a_r8_strobe_channel: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> chEn[sampleCh]);

  for (genvar k = 0; k < 4; k++) begin : gP
    logic [CNT_W-1:0] lowRun;
    always_ff @(posedge clk) begin
      if (!rstN)                    lowRun <= '0;
      else if (pwmOut[k])           lowRun <= '0;
      else if (lowRun != '1)        lowRun <= lowRun + CNT_W'(1);
    end

    a_r5_min_off: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pwmOut[k]) |-> (lowRun >= qtrLen));

    a_r6_rise_on_cmp: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pwmOut[k]) |-> $past(cmpHit[k]));

    a_r4_fall_on_event: assert property (@(posedge clk) disable iff (!rstN)
      $fell(pwmOut[k]) |-> $past(turnOff[k]));

    a_r7_hold_high: assert property (@(posedge clk) disable iff (!rstN)
      (pwmOut[k] && !turnOff[k]) |=> pwmOut[k]);
  end
endmodule

bind mphPwmSeq mphPwmSeqChk #(.CNT_W(CNT_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .pwmOut    (pwmOut),
  .cmpHit    (cmpHit),
  .turnOff   (ctlStb.turnOff),
  .chEn      (ctlStb.chEn),
  .qtrLen    (qtrLen),
  .sampleStb (sampleStb),
  .sampleCh  (sampleCh)
);

// File: tb/tb_mphPwmSeq.sv
`timescale 1ns/1ps
module tb_mphPwmSeq;
  localparam int CNT_W = 16;

  typedef struct packed {
    int per;
    int s3;
    int s4;
    int effPer;
    int nch;
    int step;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{40, 0, 0, 40, 4, 10},
    '{40, 1, 0, 40, 2, 20},
    '{40, 0, 1, 40, 3, 13},
    '{50, 0, 1, 50, 3, 16},
    '{ 5, 0, 0,  8, 4,  2},
    '{64, 1, 1, 64, 2, 32}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [CNT_W-1:0] cfgPeriod = CNT_W'(40);
  logic             strapCh3 = 1'b0;
  logic             strapCh4 = 1'b0;
  logic [3:0]       cmpHit = 4'b0;
  logic [3:0]       pwmOut;
  logic             sampleStb;
  logic [1:0]       sampleCh;

  int cyc;
  int nChecks = 0;
  int nFails  = 0;

  mphPwmSeq #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .cfgPeriod(cfgPeriod), .strapCh3(strapCh3),
    .strapCh4(strapCh4), .cmpHit(cmpHit), .pwmOut(pwmOut),
    .sampleStb(sampleStb), .sampleCh(sampleCh)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Return at the falling edge that follows rising edge m (m = 0 is the first after release)
  task automatic atNeg(input int m);
    @(negedge clk);
    while (cyc != m + 1) @(negedge clk);
  endtask

  task automatic applyReset(input int per, input bit s3, input bit s4, input logic [3:0] cmp);
    @(negedge clk);
    rstN      = 1'b0;
    cfgPeriod = CNT_W'(per);
    strapCh3  = s3;
    strapCh4  = s4;
    cmpHit    = cmp;
    repeat (3) @(negedge clk);
    check(pwmOut == 4'b0 && !sampleStb, "R1", "outputs during reset",
          int'({pwmOut, sampleStb}), 0);
    rstN = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nFails, nChecks);
    $finish;
  end

  initial begin
    // Table walk: full waveform against the phase/window rules
    for (int v = 0; v < NV; v++) begin
      int p, q, mid, badPwm, badStb, aPwm, ePwm, aStb, eStb;
      p = VECS[v].effPer;
      q = p / 4;
      mid = q / 2;
      badPwm = 0; badStb = 0;
      aPwm = 0; ePwm = 0; aStb = 0; eStb = 0;
      applyReset(VECS[v].per, VECS[v].s3 != 0, VECS[v].s4 != 0, 4'hF);
      for (int m = 0; m < 2 * p + 4; m++) begin
        logic [3:0] expP;
        bit         expS;
        int         expC;
        expP = 4'b0; expS = 1'b0; expC = 0;
        atNeg(m);
        for (int k = 0; k < VECS[v].nch; k++) begin
          int off;
          off = k * VECS[v].step;
          if (m >= off) begin
            if (((m - off) % p) >= q)  expP[k] = 1'b1;
            if (((m - off) % p) == mid) begin expS = 1'b1; expC = k; end
          end
        end
        if (!badPwm && pwmOut !== expP) begin
          badPwm = 1; aPwm = int'(pwmOut); ePwm = int'(expP);
        end
        if (!badStb && (sampleStb !== expS || (expS && sampleCh != 2'(expC)))) begin
          badStb = 1; aStb = int'({sampleStb, sampleCh}); eStb = int'({expS, 2'(expC)});
        end
      end
      check(!badPwm, "R2/R3/R4/R5", $sformatf("pwm waveform vec %0d", v), aPwm, ePwm);
      check(!badStb, "R8", $sformatf("strobe waveform vec %0d", v), aStb, eStb);
    end

    // Directed: compare held through the window, then dropped, then pulsed
    applyReset(40, 1'b0, 1'b0, 4'b1110);
    atNeg(0);
    check(pwmOut[0] == 1'b0, "R6", "ch0 low before window", int'(pwmOut[0]), 0);
    cmpHit[0] = 1'b1;
    strapCh3  = 1'b1;             // R1: straps and period ignored after release
    cfgPeriod = CNT_W'(100);
    atNeg(9);
    check(pwmOut[0] == 1'b0, "R5", "ch0 held low with cmp high in window", int'(pwmOut[0]), 0);
    cmpHit[0] = 1'b0;
    atNeg(14);
    check(pwmOut[0] == 1'b0, "R6", "ch0 stays low without cmp", int'(pwmOut[0]), 0);
    cmpHit[0] = 1'b1;
    atNeg(15);
    check(pwmOut[0] == 1'b1, "R6", "ch0 rises on next clock", int'(pwmOut[0]), 1);
    cmpHit[0] = 1'b0;
    atNeg(39);
    check(pwmOut[0] == 1'b1, "R7", "ch0 stays high after cmp drop", int'(pwmOut[0]), 1);
    check(pwmOut[2] == 1'b1, "R1", "ch2 still active after strap change", int'(pwmOut[2]), 1);
    atNeg(40);
    check(pwmOut[0] == 1'b0, "R1", "ch0 falls at original period", int'(pwmOut[0]), 0);

    // Directed: window end with cmp already high rises exactly Q clocks later
    applyReset(40, 1'b0, 1'b0, 4'b0000);
    atNeg(9);
    cmpHit[1] = 1'b1;
    atNeg(19);
    check(pwmOut[1] == 1'b0, "R5", "ch1 low on last window clock", int'(pwmOut[1]), 0);
    atNeg(20);
    check(pwmOut[1] == 1'b1, "R6", "ch1 rises at window end", int'(pwmOut[1]), 1);

    // Directed: two-channel mode, upper channels with cmp high never drive
    applyReset(40, 1'b1, 1'b0, 4'hF);
    atNeg(60);
    check(pwmOut[3:2] == 2'b00, "R2", "unused channels low", int'(pwmOut[3:2]), 0);

    $display("Result: errors=%0d of %0d checks", nFails, nChecks);
    $finish;
  end
endmodule